// File: doc/BRIEF.md
# USB Host Frame Interval Timer

This block keeps frame timing for a USB host controller. It runs on a bit-rate clock enable (one pulse per 12 MHz bit time) and counts a 14-bit remaining count down toward zero. When a tick finds the count at zero, a frame boundary occurs. The count reloads from a programmable frame interval, a frame-interval toggle bit is copied across from the interval register, a 16-bit frame number advances, and start-of-frame and end-of-frame events pulse. Software reads and writes the interval, remaining, frame-number, periodic-start and low-speed-threshold registers through a byte-enabled write port and a combinational read port. Each register keeps only its defined field widths.

A run enable gates the timer. While it is low, the timer holds every value. Transfer scheduling at frame boundaries is done elsewhere; this block only provides the timing and the events.

Top module: `frame_timer`

## Requirements
- R1: After reset the interval register reads 0x00002EDF (11999). The remaining, frame-number, periodic-start and low-speed-threshold registers read 0, and both event outputs are low.
- R2: A tick is a cycle with runEn and bitTick both high. On a tick, a non-zero remaining count decrements by one. In any cycle that is not a tick, the remaining count, toggle bit and frame number hold.
- R3: On a tick that finds the remaining count at zero, the count reloads from interval bits 13:0 and then decrements by one in the same tick (it stays 0 if those bits are 0). Interval bit 31 is copied into remaining bit 31.
- R4: At each frame boundary the 16-bit frame number increments by one, wrapping from 0xFFFF to 0.
- R5: sofPulse and eofPulse are both high for exactly the one cycle after a boundary tick, and low at all other times.
- R6: The remaining register is at select 1 and reads as {bit31 toggle, bits 30:14 zero, bits 13:0 count}. A write with byte 0 enabled sets bits 7:0. Byte 1 sets bits 13:8 only. Byte 2 is ignored. Byte 3 sets only bit 31.
- R7: The register selects are 0 interval, 2 frame number, 3 periodic start and 4 low-speed threshold. The interval keeps all 32 bits. The frame number keeps bits 15:0, the periodic start keeps bits 13:0 and the low-speed threshold keeps bits 11:0. Bytes and bits above each of those fields ignore writes and read 0.
- R8: When a write and a tick land in the same cycle, the written bytes take the written value and the tick result is kept for the bytes that are not written.
- R9: Selects 5 to 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Timer run enable |
| bitTick | input | 1 | One-cycle bit-time clock enable |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register select for writes |
| wrBe | input | 4 | Byte enables for the write |
| wrData | input | 32 | Write data |
| rdSel | input | 3 | Register select for reads |
| rdData | output | 32 | Read data for rdSel |
| sofPulse | output | 1 | Start-of-frame event |
| eofPulse | output | 1 | End-of-frame event |

## Verification
A wrong remaining count appears on the remaining read at the next sample after the tick that produced it. The same fault then moves the boundary, so the event pulses and the frame-number read go wrong within one frame interval. A toggle or frame-number fault at a boundary is visible in the cycle right after that boundary. A masking error on a write shows on the first read of the register that follows. The stimulus uses short intervals so that boundaries come every few ticks.

// File: rtl/ft_pkg.sv
package ft_pkg;
  localparam int DATA_W   = 32;
  localparam int BYTES    = DATA_W / 8;
  localparam int NUM_REGS = 5;
  localparam int SEL_W    = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_INTERVAL = 3'd0,
    SEL_REMAIN   = 3'd1,
    SEL_FRAMENUM = 3'd2,
    SEL_PERSTART = 3'd3,
    SEL_LSTHRESH = 3'd4
  } regSel_e;

  typedef struct packed {
    logic                            advance;
    logic [NUM_REGS-1:0][BYTES-1:0]  byteWr;
  } strobe_t;
endpackage

// File: rtl/ft_ctrl.sv
module ft_ctrl
  import ft_pkg::*;
(
  input  logic             runEn,
  input  logic             bitTick,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [BYTES-1:0] wrBe,
  output strobe_t          st
);
  logic [NUM_REGS-1:0][BYTES-1:0] byteWr;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
    assign byteWr[r] = (wrEn && (wrSel == SEL_W'(r))) ? wrBe : '0;
  end

  assign st.advance = runEn & bitTick;
  assign st.byteWr  = byteWr;
endmodule

// File: rtl/ft_datapath.sv
module ft_datapath
  import ft_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int FN_W  = 16,
  parameter int PS_W  = 14,
  parameter int LS_W  = 12,
  parameter logic [CNT_W-1:0] RESET_INTERVAL = 14'd11999
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              sofPulse,
  output logic              eofPulse
);
  localparam int TOG = DATA_W - 1;

  logic [DATA_W-1:0] intervalQ, intervalD;
  logic [CNT_W-1:0]  remQ, remD;
  logic              togQ, togD;
  logic [FN_W-1:0]   fnQ, fnD;
  logic [PS_W-1:0]   psQ, psD;
  logic [LS_W-1:0]   lsQ, lsD;
  logic              boundary;

  assign boundary = st.advance && (remQ == '0);

  // timer step, then software bytes override
  always_comb begin
    remD = remQ;
    togD = togQ;
    fnD  = fnQ;
    if (st.advance) begin
      if (boundary) begin
        remD = intervalQ[CNT_W-1:0];
        togD = intervalQ[TOG];
        fnD  = fnQ + FN_W'(1);
      end
      if (remD != '0) remD = remD - CNT_W'(1);
    end
    for (int i = 0; i < CNT_W; i++)
      if (st.byteWr[SEL_REMAIN][i/8] && (i/8 != 2)) remD[i] = wrData[i];
    if (st.byteWr[SEL_REMAIN][BYTES-1]) togD = wrData[TOG];
    for (int i = 0; i < FN_W; i++)
      if (st.byteWr[SEL_FRAMENUM][i/8]) fnD[i] = wrData[i];
  end

  always_comb begin
    intervalD = intervalQ;
    psD       = psQ;
    lsD       = lsQ;
    for (int i = 0; i < DATA_W; i++)
      if (st.byteWr[SEL_INTERVAL][i/8]) intervalD[i] = wrData[i];
    for (int i = 0; i < PS_W; i++)
      if (st.byteWr[SEL_PERSTART][i/8]) psD[i] = wrData[i];
    for (int i = 0; i < LS_W; i++)
      if (st.byteWr[SEL_LSTHRESH][i/8]) lsD[i] = wrData[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalQ <= DATA_W'(RESET_INTERVAL);
      remQ      <= '0;
      togQ      <= 1'b0;
      fnQ       <= '0;
      psQ       <= '0;
      lsQ       <= '0;
      sofPulse  <= 1'b0;
      eofPulse  <= 1'b0;
    end else begin
      intervalQ <= intervalD;
      remQ      <= remD;
      togQ      <= togD;
      fnQ       <= fnD;
      psQ       <= psD;
      lsQ       <= lsD;
      sofPulse  <= boundary;
      eofPulse  <= boundary;
    end
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      SEL_INTERVAL: rdData = intervalQ;
      SEL_REMAIN: begin
        rdData[CNT_W-1:0] = remQ;
        rdData[TOG]       = togQ;
      end
      SEL_FRAMENUM: rdData[FN_W-1:0] = fnQ;
      SEL_PERSTART: rdData[PS_W-1:0] = psQ;
      SEL_LSTHRESH: rdData[LS_W-1:0] = lsQ;
      default:      rdData = '0;
    endcase
  end

  logic remWr, fnWr;
  assign remWr = |st.byteWr[SEL_REMAIN];
  assign fnWr  = |st.byteWr[SEL_FRAMENUM];

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!st.advance && !remWr && !fnWr) |=> ($stable(remQ) && $stable(togQ) && $stable(fnQ)));

  p_dec_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st.advance && remQ != '0 && !remWr) |=> (remQ == $past(remQ) - CNT_W'(1)));

  p_tog_r3: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && !st.byteWr[SEL_REMAIN][BYTES-1]) |=> (togQ == $past(intervalQ[TOG])));

  p_fn_r4: assert property (@(posedge clk) disable iff (!rstN)
    (boundary && !fnWr) |=> (fnQ == $past(fnQ) + FN_W'(1)));

  p_sof_r5: assert property (@(posedge clk) disable iff (!rstN)
    boundary |=> (sofPulse && eofPulse));

  p_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> (!sofPulse && !eofPulse));
endmodule

// File: rtl/frame_timer.sv
module frame_timer
  import ft_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int FN_W  = 16,
  parameter int PS_W  = 14,
  parameter int LS_W  = 12,
  parameter logic [CNT_W-1:0] RESET_INTERVAL = 14'd11999
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              bitTick,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [BYTES-1:0]  wrBe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              sofPulse,
  output logic              eofPulse
);
  strobe_t st;

  ft_ctrl u_ctrl (
    .runEn  (runEn),
    .bitTick(bitTick),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrBe   (wrBe),
    .st     (st)
  );

  ft_datapath #(
    .CNT_W(CNT_W), .FN_W(FN_W), .PS_W(PS_W), .LS_W(LS_W),
    .RESET_INTERVAL(RESET_INTERVAL)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .wrData  (wrData),
    .rdSel   (rdSel),
    .rdData  (rdData),
    .sofPulse(sofPulse),
    .eofPulse(eofPulse)
  );
endmodule

// File: tb/tb_frame_timer.sv
module tb_frame_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0, bitTick = 1'b0, wrEn = 1'b0;
  logic [2:0]  wrSel = '0, rdSel = '0;
  logic [3:0]  wrBe = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        sofPulse, eofPulse;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [31:0] mInt;
  logic [13:0] mRem;
  logic        mTog;
  logic [15:0] mFn;
  logic [13:0] mPs;
  logic [11:0] mLs;
  logic        mPulse;

  frame_timer dut (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] modelRead(input logic [2:0] s);
    case (s)
      3'd0: return mInt;
      3'd1: return {mTog, 17'b0, mRem};
      3'd2: return {16'b0, mFn};
      3'd3: return {18'b0, mPs};
      3'd4: return {20'b0, mLs};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] byteMerge(input logic [31:0] o, input logic [31:0] d,
                                            input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mInt = 32'h0000_2EDF; mRem = '0; mTog = 0; mFn = '0; mPs = '0; mLs = '0; mPulse = 0;
  endtask

  // one cycle: drive at negedge, compare current state, advance model
  task automatic step(input logic run, input logic tk, input logic we, input logic [2:0] ws,
                      input logic [3:0] be, input logic [31:0] d, input logic [2:0] rs,
                      input string tag);
    logic [13:0] c;
    logic        t;
    logic [15:0] f;
    logic [31:0] tmp;
    @(negedge clk);
    runEn = run; bitTick = tk; wrEn = we; wrSel = ws; wrBe = be; wrData = d; rdSel = rs;
    #1;
    check(tag, rdData, modelRead(rs));
    check("R5", {31'b0, sofPulse}, {31'b0, mPulse});
    check("R5", {31'b0, eofPulse}, {31'b0, mPulse});
    c = mRem; t = mTog; f = mFn; mPulse = 0;
    if (run && tk) begin
      if (c == 0) begin
        mPulse = 1; c = mInt[13:0]; t = mInt[31]; f = mFn + 16'd1;
      end
      if (c != 0) c = c - 14'd1;
    end
    if (we) begin
      case (ws)
        3'd0: mInt = byteMerge(mInt, d, be);
        3'd1: begin
          tmp = byteMerge({18'b0, c}, d, be & 4'b0011);
          c = tmp[13:0];
          if (be[3]) t = d[31];
        end
        3'd2: begin tmp = byteMerge({16'b0, f}, d, be); f = tmp[15:0]; end
        3'd3: begin tmp = byteMerge({18'b0, mPs}, d, be); mPs = tmp[13:0]; end
        3'd4: begin tmp = byteMerge({20'b0, mLs}, d, be); mLs = tmp[11:0]; end
        default: ;
      endcase
    end
    mRem = c; mTog = t; mFn = f;
  endtask

  function automatic string tagFor(input logic [2:0] s);
    case (s)
      3'd1: return "R2";
      3'd2: return "R4";
      3'd0, 3'd3, 3'd4: return "R7";
      default: return "R9";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R1 reset values
    for (int s = 0; s < 5; s++) step(0, 0, 0, 0, 0, 0, 3'(s), "R1");
    // R3: interval 3 with toggle set; first tick from zero reloads and decrements
    step(0, 0, 1, 3'd0, 4'hF, 32'h8000_0003, 3'd1, "R7");
    step(1, 1, 0, 0, 0, 0, 3'd1, "R3");
    step(0, 0, 0, 0, 0, 0, 3'd1, "R3");   // expect 0x80000002, pulse seen
    for (int k = 0; k < 6; k++) step(1, 1, 0, 0, 0, 0, 3'd1, "R3");
    // R2 hold with runEn low, and tick low
    step(0, 1, 0, 0, 0, 0, 3'd1, "R2");
    step(1, 0, 0, 0, 0, 0, 3'd1, "R2");
    step(0, 0, 0, 0, 0, 0, 3'd1, "R2");
    // R3 zero interval stays at zero with boundary every tick
    step(0, 0, 1, 3'd0, 4'hF, 32'h0000_0000, 3'd1, "R3");
    step(0, 0, 1, 3'd1, 4'h3, 32'h0, 3'd1, "R3");
    for (int k = 0; k < 3; k++) step(1, 1, 0, 0, 0, 0, 3'd1, "R3");
    // R4 frame number wrap
    step(0, 0, 1, 3'd2, 4'hF, 32'hABCD_FFFF, 3'd2, "R4");
    step(1, 1, 0, 0, 0, 0, 3'd2, "R4");
    step(0, 0, 0, 0, 0, 0, 3'd2, "R4");
    // R6 remaining masks, per byte
    step(0, 0, 1, 3'd1, 4'hF, 32'hFFFF_FFFF, 3'd1, "R6");
    step(0, 0, 1, 3'd1, 4'h4, 32'h0000_0000, 3'd1, "R6");
    step(0, 0, 1, 3'd1, 4'h8, 32'h7FFF_FFFF, 3'd1, "R6");
    step(0, 0, 1, 3'd1, 4'h2, 32'h0000_0000, 3'd1, "R6");
    step(0, 0, 0, 0, 0, 0, 3'd1, "R6");
    // R7 field widths
    step(0, 0, 1, 3'd3, 4'hF, 32'hFFFF_FFFF, 3'd3, "R7");
    step(0, 0, 1, 3'd4, 4'hF, 32'hFFFF_FFFF, 3'd4, "R7");
    step(0, 0, 1, 3'd2, 4'hC, 32'hFFFF_FFFF, 3'd3, "R7");
    step(0, 0, 0, 0, 0, 0, 3'd4, "R7");
    step(0, 0, 0, 0, 0, 0, 3'd2, "R7");
    // R8 write collides with tick
    step(0, 0, 1, 3'd0, 4'hF, 32'h0000_0010, 3'd1, "R8");
    step(1, 1, 1, 3'd1, 4'h1, 32'h0000_0055, 3'd1, "R8");
    step(1, 1, 1, 3'd2, 4'h1, 32'h0000_0077, 3'd1, "R8");
    step(0, 0, 0, 0, 0, 0, 3'd1, "R8");
    step(0, 0, 0, 0, 0, 0, 3'd2, "R8");
    // R9 unused selects
    for (int s = 5; s < 8; s++) step(0, 0, 1, 3'(s), 4'hF, 32'hFFFF_FFFF, 3'(s), "R9");
    for (int s = 0; s < 5; s++) step(0, 0, 0, 0, 0, 0, 3'(s), "R9");
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [2:0]  ws = 3'($urandom % 6);
      logic [31:0] d  = $urandom;
      logic [2:0]  rs = 3'($urandom % 8);
      if (ws == 3'd0 && ($urandom % 4 != 0)) d = d & 32'h8000_000F;
      if (ws == 3'd1 && ($urandom % 2 == 0)) d = d & 32'h8000_0007;
      step(($urandom % 8) != 0, $urandom % 2, ($urandom % 8) == 0, ws,
           4'($urandom), d, rs, tagFor(rs));
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule